// File: doc/BRIEF.md
# PCIe Configuration Window Base Decoder

This block is one 64-bit base register of a host bridge's configuration space. Software programs it through byte-enabled configuration writes on a 32-bit data bus. The block turns the stored value into a live description of the memory-mapped PCIe configuration window: an enable, a naturally aligned base address and a window length. It also flags any 64-bit request address that falls inside the active window, so that the surrounding fabric can steer that request to the configuration path.

The length field picks one of three window sizes. The part of the address taken as base depends on that choice, because a smaller window can sit on a finer alignment. One encoding of the length field is reserved. A write that leaves the field at that code does not change the mapping in force. Instead, a one-cycle error flag is raised.

Top module: `ecam_window_dec`

## Requirements
- R1: After reset the window is disabled, the base is 0x0_B000_0000, the length is 256 MiB and the error flag is low. Reads return 0xB000_0000 for the low dword and 0 for the high dword.
- R2: The register sits at two dword addresses: REG_DW (0x018 by default) holds bits 31:0 and REG_DW+1 holds bits 63:32. Writes are merged per byte lane under cfg_be, and a lane whose enable bit is 0 keeps its old byte.
- R3: Bit 0 is the enable and bits 2:1 are the length code. Bits 35:26 are the base bits. All other bits cannot be written and read as 0.
- R4: Length code 00 decodes to a 256 MiB window, 01 to 128 MiB and 10 to 64 MiB. The length is given in bytes on win_len.
- R5: The base is taken from register bits 35:28 for 256 MiB, bits 35:27 for 128 MiB and bits 35:26 for 64 MiB. All lower base bits are zero, so the base is always aligned to the window length.
- R6: When a write leaves the length code at 11, win_en, win_base and win_len keep their previous values and win_len_err is high for exactly the following cycle. The register still stores and reads back the 11 code.
- R7: The decoded outputs change on the same clock edge as a write that enables at least one byte lane of either dword. A write with no byte lane enabled, or to any other address, leaves the outputs and the register unchanged.
- R8: req_hit is combinational. It is high exactly when the window is enabled and win_base <= req_addr < win_base + win_len, compared over all 64 address bits.
- R9: With the enable bit clear, req_hit stays low for every address, while base and length are still decoded.
- R10: cfg_rdata is loaded one cycle after cfg_rd_en with the addressed dword, or with 0 for any other address. It holds its value in cycles without cfg_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | CFG_AW | Dword address of the access |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| win_en | output | 1 | Window enabled |
| win_base | output | 64 | Decoded window base address |
| win_len | output | 64 | Decoded window length in bytes |
| win_len_err | output | 1 | One-cycle pulse on a reserved length code |
| req_addr | input | 64 | Request address to classify |
| req_hit | output | 1 | Request address falls in the active window |

## Verification
The checker watches several rules on every cycle. The mapping stays put in cycles that follow no write and in the cycle of an error pulse. Every error pulse is traced back to a write. The length is always a single power of two and the base is aligned to it. Every hit implies an enabled window and an address inside it. The exact base mask for each length code, the byte-lane merge, and the masking of unused bits can only be shown by the bench's scenarios, which compare against fixed expected values. The same applies to the retained mapping after a reserved code, the one-cycle pulse width, the read-back path and the hit boundaries on either side of the window.

// File: rtl/ecamw_pkg.sv
package ecamw_pkg;

  localparam int unsigned AW = 64;

  typedef enum logic [1:0] {
    CODE_256M = 2'b00,
    CODE_128M = 2'b01,
    CODE_64M  = 2'b10,
    CODE_RSVD = 2'b11
  } win_code_e;

  typedef struct packed {
    logic          en;
    logic [AW-1:0] base;
    logic [AW-1:0] len;
  } win_map_t;

  // Window length in bytes; the smallest window is 2**min_log2.
  function automatic logic [AW-1:0] code_len(win_code_e c, int unsigned min_log2);
    logic [AW-1:0] one;
    one = {{(AW-1){1'b0}}, 1'b1};
    case (c)
      CODE_256M: code_len = one << (min_log2 + 2);
      CODE_128M: code_len = one << (min_log2 + 1);
      CODE_64M:  code_len = one << min_log2;
      default:   code_len = '0;
    endcase
  endfunction

  // Base mask: bits from base_msb down to log2(window length).
  function automatic logic [AW-1:0] code_mask(win_code_e c, int unsigned min_log2,
                                              int unsigned base_msb);
    logic [AW-1:0] upper;
    logic [AW-1:0] one;
    one   = {{(AW-1){1'b0}}, 1'b1};
    upper = (one << (base_msb + 1)) - one;
    code_mask = upper & ~(code_len(c, min_log2) - one);
  endfunction

  function automatic win_map_t decode_reg(logic [AW-1:0] r, int unsigned min_log2,
                                          int unsigned base_msb);
    win_code_e c;
    win_map_t  m;
    c      = win_code_e'(r[2:1]);
    m.en   = r[0];
    m.len  = code_len(c, min_log2);
    m.base = r & code_mask(c, min_log2, base_msb);
    return m;
  endfunction

endpackage

// File: rtl/ecamw_cfg_regs.sv
module ecamw_cfg_regs #(
  parameter int unsigned   CFG_AW    = 10,
  parameter int unsigned   REG_DW    = 'h018,
  parameter logic [63:0]   WR_MASK   = 64'h0000_000F_FC00_0007,
  parameter logic [63:0]   RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CFG_AW-1:0] dw_addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              upd,
  output logic [63:0]       reg_nxt
);

  localparam int unsigned NDW   = 2;
  localparam int unsigned NLANE = 4;

  logic [63:0]    reg_q;
  logic [63:0]    reg_merge;
  logic [NDW-1:0] dw_sel;
  logic [31:0]    rdata_d;
  logic [31:0]    rdata_q;

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    assign dw_sel[d] = (dw_addr == CFG_AW'(REG_DW + d));
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign reg_merge[d*32 + l*8 +: 8] =
        (wr_en && dw_sel[d] && be[l]) ? wdata[l*8 +: 8] : reg_q[d*32 + l*8 +: 8];
    end
  end

  always_comb begin
    upd     = wr_en && (|dw_sel) && (|be);
    reg_nxt = reg_merge & WR_MASK;
    if (dw_sel[0])      rdata_d = reg_q[31:0];
    else if (dw_sel[1]) rdata_d = reg_q[63:32];
    else                rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= RESET_VAL & WR_MASK;
      rdata_q <= '0;
    end else begin
      if (upd)   reg_q   <= reg_nxt;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ecamw_decode.sv
module ecamw_decode
  import ecamw_pkg::*;
#(
  parameter int unsigned MIN_LOG2  = 26,
  parameter int unsigned BASE_MSB  = 35,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [63:0]   reg_nxt,
  output logic          en,
  output logic [AW-1:0] base,
  output logic [AW-1:0] len,
  output logic          err
);

  localparam win_map_t RST_MAP = decode_reg(RESET_VAL, MIN_LOG2, BASE_MSB);

  win_map_t map_q, map_d;
  logic     map_ce;
  logic     err_d, err_q;
  logic     rsvd;

  always_comb begin
    rsvd   = (win_code_e'(reg_nxt[2:1]) == CODE_RSVD);
    map_d  = decode_reg(reg_nxt, MIN_LOG2, BASE_MSB);
    map_ce = upd && !rsvd;
    err_d  = upd && rsvd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= RST_MAP;
      err_q <= 1'b0;
    end else begin
      if (map_ce) map_q <= map_d;
      err_q <= err_d;
    end
  end

  assign en   = map_q.en;
  assign base = map_q.base;
  assign len  = map_q.len;
  assign err  = err_q;

endmodule

// File: rtl/ecamw_hit.sv
module ecamw_hit
  import ecamw_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic          hit
);

  logic [AW-1:0] amask;

  always_comb begin
    amask = ~(len - {{(AW-1){1'b0}}, 1'b1});
    hit   = en && ((addr & amask) == base);
  end

endmodule

// File: rtl/ecam_window_dec.sv
module ecam_window_dec
  import ecamw_pkg::*;
#(
  parameter int unsigned CFG_AW    = 10,
  parameter int unsigned REG_DW    = 'h018,
  parameter int unsigned MIN_LOG2  = 26,
  parameter int unsigned BASE_MSB  = 35,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [CFG_AW-1:0] cfg_dw_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              win_en,
  output logic [63:0]       win_base,
  output logic [63:0]       win_len,
  output logic              win_len_err,
  input  logic [63:0]       req_addr,
  output logic              req_hit
);

  localparam logic [63:0] ONE      = 64'd1;
  localparam logic [63:0] BASE_FLD = ((ONE << (BASE_MSB + 1)) - ONE) & ~((ONE << MIN_LOG2) - ONE);
  localparam logic [63:0] WR_MASK  = BASE_FLD | 64'h7;

  logic        upd;
  logic [63:0] reg_nxt;

  ecamw_cfg_regs #(
    .CFG_AW    (CFG_AW),
    .REG_DW    (REG_DW),
    .WR_MASK   (WR_MASK),
    .RESET_VAL (RESET_VAL)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .rd_en   (cfg_rd_en),
    .dw_addr (cfg_dw_addr),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .upd     (upd),
    .reg_nxt (reg_nxt)
  );

  ecamw_decode #(
    .MIN_LOG2  (MIN_LOG2),
    .BASE_MSB  (BASE_MSB),
    .RESET_VAL (RESET_VAL)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .reg_nxt (reg_nxt),
    .en      (win_en),
    .base    (win_base),
    .len     (win_len),
    .err     (win_len_err)
  );

  ecamw_hit u_hit (
    .addr (req_addr),
    .en   (win_en),
    .base (win_base),
    .len  (win_len),
    .hit  (req_hit)
  );

endmodule

// File: rtl/ecam_window_dec_chk.sv
module ecam_window_dec_chk #(
  parameter int unsigned CFG_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic              cfg_rd_en,
  input logic [CFG_AW-1:0] cfg_dw_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              win_en,
  input logic [63:0]       win_base,
  input logic [63:0]       win_len,
  input logic              win_len_err,
  input logic [63:0]       req_addr,
  input logic              req_hit
);

  // R7: the mapping moves only after a write
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_en) |-> ($stable(win_en) && $stable(win_base) && $stable(win_len)));

  // R6: a reserved code leaves the mapping in force
  a_r6_reserved_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
    win_len_err |-> ($stable(win_en) && $stable(win_base) && $stable(win_len)));

  // R6: the error pulse is caused by a write
  a_r6_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    win_len_err |-> $past(cfg_wr_en));

  // R4: the length is a single power of two
  a_r4_len_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_len) == 1);

  // R5: base aligned to the length
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base & (win_len - 64'd1)) == 64'd0);

  // R9: no hit while disabled
  a_r9_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> win_en);

  // R8: a hit lies inside the window
  a_r8_hit_inside: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> ((req_addr >= win_base) && ((req_addr - win_base) < win_len)));

endmodule

bind ecam_window_dec ecam_window_dec_chk #(.CFG_AW(CFG_AW)) u_chk (.*);

// File: tb/ecam_window_dec_bench.sv
module ecam_window_dec_bench;

  localparam int unsigned CFG_AW = 10;
  localparam logic [CFG_AW-1:0] A_LO  = 10'h018;
  localparam logic [CFG_AW-1:0] A_HI  = 10'h019;
  localparam logic [CFG_AW-1:0] A_OTH = 10'h020;
  localparam logic [63:0] L256 = 64'h1000_0000;
  localparam logic [63:0] L128 = 64'h0800_0000;
  localparam logic [63:0] L64  = 64'h0400_0000;

  logic              clk;
  logic              rst_n;
  logic              cfg_wr_en;
  logic              cfg_rd_en;
  logic [CFG_AW-1:0] cfg_dw_addr;
  logic [3:0]        cfg_be;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic              win_en;
  logic [63:0]       win_base;
  logic [63:0]       win_len;
  logic              win_len_err;
  logic [63:0]       req_addr;
  logic              req_hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  ecam_window_dec u_ecam_window_dec (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [CFG_AW-1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(logic [CFG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_dw_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic chk_map(string req, logic e, logic [63:0] b, logic [63:0] l);
    chk(req, "win_en", 64'(win_en), 64'(e));
    chk(req, "win_base", win_base, b);
    chk(req, "win_len", win_len, l);
  endtask

  task automatic probe(string req, logic [63:0] a, logic exp);
    req_addr = a;
    #1;
    chk(req, "req_hit", 64'(req_hit), 64'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_map("R1", 1'b0, 64'h0_B000_0000, L256);
    chk("R1", "err", 64'(win_len_err), 64'd0);
    rd(A_LO, d); chk("R1", "rd lo", 64'(d), 64'hB000_0000);
    rd(A_HI, d); chk("R1", "rd hi", 64'(d), 64'h0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(A_LO, 4'b0001, 32'hFFFF_FFF9);
    chk_map("R7", 1'b1, 64'h0_B000_0000, L256);
    rd(A_LO, d); chk("R2", "lane0 only", 64'(d), 64'hB000_0001);
    wr(A_HI, 4'b0010, 32'hFFFF_FFFF);
    rd(A_HI, d); chk("R3", "unused hi bits", 64'(d), 64'h0);
    wr(A_HI, 4'b0001, 32'h0000_00A5);
    rd(A_HI, d); chk("R3", "base 35:32", 64'(d), 64'h5);
    chk_map("R5", 1'b1, 64'h5_B000_0000, L256);
  endtask

  task automatic t_modes();
    wr(A_LO, 4'b1111, 32'hFC00_0003);
    chk_map("R4", 1'b1, 64'h5_F800_0000, L128);
    wr(A_LO, 4'b1111, 32'hFC00_0005);
    chk_map("R5", 1'b1, 64'h5_FC00_0000, L64);
    wr(A_LO, 4'b1111, 32'hFC00_0001);
    chk_map("R4", 1'b1, 64'h5_F000_0000, L256);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_LO, 4'b1111, 32'h0400_0006);
    chk("R6", "err pulse", 64'(win_len_err), 64'd1);
    chk_map("R6", 1'b1, 64'h5_F000_0000, L256);
    @(negedge clk);
    chk("R6", "err one cycle", 64'(win_len_err), 64'd0);
    rd(A_LO, d); chk("R6", "rsvd stored", 64'(d), 64'h0400_0006);
    chk_map("R6", 1'b1, 64'h5_F000_0000, L256);
    wr(A_LO, 4'b1111, 32'h0400_0004);
    chk_map("R9", 1'b0, 64'h5_0400_0000, L64);
    chk("R6", "no err", 64'(win_len_err), 64'd0);
  endtask

  task automatic t_no_effect();
    logic [31:0] d;
    wr(A_LO, 4'b0000, 32'hFFFF_FFFF);
    chk_map("R7", 1'b0, 64'h5_0400_0000, L64);
    rd(A_LO, d); chk("R7", "be0 reg", 64'(d), 64'h0400_0004);
    wr(A_OTH, 4'b1111, 32'hFFFF_FFFF);
    chk_map("R7", 1'b0, 64'h5_0400_0000, L64);
    rd(A_OTH, d); chk("R10", "miss reads 0", 64'(d), 64'h0);
    rd(A_LO, d); chk("R7", "other addr reg", 64'(d), 64'h0400_0004);
  endtask

  task automatic t_hit();
    probe("R9", 64'h5_0400_0000, 1'b0);
    probe("R9", 64'h5_0400_1000, 1'b0);
    wr(A_LO, 4'b1111, 32'h0400_0005);
    probe("R8", 64'h5_0400_0000, 1'b1);
    probe("R8", 64'h5_07FF_FFFF, 1'b1);
    probe("R8", 64'h5_03FF_FFFF, 1'b0);
    probe("R8", 64'h5_0800_0000, 1'b0);
    probe("R8", 64'h105_0400_0000, 1'b0);
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    rd(A_LO, d); chk("R10", "rd lo", 64'(d), 64'h0400_0005);
    wr(A_LO, 4'b1111, 32'h0000_0001);
    @(negedge clk);
    chk("R10", "rdata holds", 64'(cfg_rdata), 64'h0400_0005);
    rd(A_LO, d); chk("R10", "rd new", 64'(d), 64'h0000_0001);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
    cfg_dw_addr = '0; cfg_be = '0; cfg_wdata = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_modes();
    t_reserved();
    t_no_effect();
    t_hit();
    t_read_hold();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule